// File: doc/BRIEF.md
# Two-Level Priority Message Bus Arbiter

This block is the central arbiter of a shared message bus with eight masters. Each master pulls its own active-low request line to ask for the bus. The arbiter answers with exactly one active-low grant at a time and keeps that grant for the whole message envelope the chosen master then drives. A single shared active-low line tells the arbiter that some master has a high-priority data message waiting. A per-port flag marks which masters take part in that high-priority level. Command traffic uses the low level.

Within each level the arbiter rotates fairly, and each level keeps its own rotation state. A granted master that does not start its envelope promptly loses the grant, so a silent master cannot hold the bus. A load regulator counts the data-message cycles seen in a sliding window of recent clocks. It pulls an active-low overload output once that count reaches a programmable budget, which tells the masters that no more forwarding load can be taken.

Top module: `msg_bus_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every bit of `gnt_n` is 1. `ovld_n` is 1 while `ovld_thresh` is above zero. Both rotation pointers restart so that the first search in each level begins at requester 0.
- R2: At most one bit of `gnt_n` is 0 in any cycle.
- R3: A grant is issued only from idle, at a clock edge where `msg_env_n` is 1 and the granted requester's `req_n` bit is 0. The grant is visible in the cycle after that edge. While `msg_env_n` is 0 and no grant is held, no grant is issued.
- R4: While `hp_req_n` is 0 and at least one requesting port has its `hp_flag` bit set to 1, only such flagged requesters can win. If `hp_req_n` is 0 but no flagged port is requesting, arbitration falls back to the low level.
- R5: At the low level every requester with `req_n` low is eligible. The winner is the first requester after the last low-level winner, searching upward by index and wrapping from 7 to 0.
- R6: The high and low levels each keep their own last-winner pointer. A grant at one level does not move the pointer of the other level.
- R7: Once the granted master drives `msg_env_n` to 0, the grant is held unchanged while `msg_env_n` stays 0. The grant is removed at the first edge that samples `msg_env_n` back at 1, so `gnt_n` returns to all ones one clock after the envelope ends.
- R8: If `msg_env_n` has not gone to 0 at any of the 4 edges that follow the grant, the grant is withdrawn at the 4th of those edges. The withdrawn requester still counts as the last winner of its level.
- R9: A data cycle is a clock edge at which a high-level grant is held and `msg_env_n` is 0. `ovld_n` is 0 exactly when the number of data cycles among the last WINDOW edges is greater than or equal to `ovld_thresh`. Low-level messages never add to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_REQ | Per-master bus request, active low |
| hp_req_n | input | 1 | Shared high-priority request, active low |
| hp_flag | input | NUM_REQ | Per-master high-level membership flag, active high |
| msg_env_n | input | 1 | Message envelope driven by the bus owner, active low |
| ovld_thresh | input | $clog2(WINDOW+1) | Data-cycle budget per window |
| gnt_n | output | NUM_REQ | Per-master bus grant, active low |
| ovld_n | output | 1 | Forwarding bandwidth exhausted, active low |

## Verification
On every cycle the assertions check the grant-level rules: grants are at most one-hot, and every new grant follows an idle bus and a live request. They also check that a grant stays put while its envelope runs, that the high level wins when a flagged master asks, and that no unstarted grant outlives its start window. The order of rotation inside each level, the separate pointers, the fallback when the shared line has no flagged requester, and the exact edge at which the overload output follows the windowed data-cycle count are shown only by the bench's directed scenarios. Those scenarios predict each winner and each overload transition from the rules above.

// File: rtl/msgarb_pkg.sv
`timescale 1ns/1ps
package msgarb_pkg;

    localparam int NUM_LVL = 2;
    localparam int LVL_LO  = 0;
    localparam int LVL_HI  = 1;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_BUSY = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic valid;
        logic hi;
    } grant_tag_t;

    function automatic logic pick_high(input logic hp_line, input logic hi_found);
        return hp_line && hi_found;
    endfunction

endpackage

// File: rtl/msgarb_rr_pick.sv
`timescale 1ns/1ps
module msgarb_rr_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] win
);
    always_comb begin
        int cand;
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!found && elig[cand]) begin
                found = 1'b1;
                win   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/msgarb_load_reg.sv
`timescale 1ns/1ps
module msgarb_load_reg #(
    parameter int WINDOW = 64,
    localparam int CW = $clog2(WINDOW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_cycle,
    input  logic [CW-1:0] thresh,
    output logic          overload
);
    logic [WINDOW-1:0] hist_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     add_v;
    logic [CW-1:0]     sub_v;

    assign add_v = {{(CW-1){1'b0}}, data_cycle};
    assign sub_v = {{(CW-1){1'b0}}, hist_q[WINDOW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else begin
            hist_q <= {hist_q[WINDOW-2:0], data_cycle};
            cnt_q  <= cnt_q + add_v - sub_v;
        end
    end

    assign overload = (cnt_q >= thresh);
endmodule

// File: rtl/msgarb_ctrl.sv
`timescale 1ns/1ps
module msgarb_ctrl
    import msgarb_pkg::*;
#(
    parameter int N             = 8,
    parameter int START_TIMEOUT = 4,
    localparam int IW = $clog2(N),
    localparam int TW = $clog2(START_TIMEOUT + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hp_line,
    input  logic                        env,
    input  logic [NUM_LVL-1:0]          found,
    input  logic [NUM_LVL-1:0][IW-1:0]  win,
    output logic [N-1:0]                gnt,
    output logic [NUM_LVL-1:0][IW-1:0]  last,
    output logic                        data_cycle
);
    arb_state_e  state_q;
    grant_tag_t  tag_q;
    logic [IW-1:0] idx_q;
    logic [TW-1:0] timer_q;

    logic          use_hi;
    logic          any_found;
    logic [IW-1:0] pick_idx;

    always_comb begin
        use_hi    = pick_high(hp_line, found[LVL_HI]);
        any_found = use_hi || found[LVL_LO];
        pick_idx  = use_hi ? win[LVL_HI] : win[LVL_LO];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            tag_q   <= '0;
            idx_q   <= '0;
            timer_q <= '0;
            for (int l = 0; l < NUM_LVL; l++) begin
                last[l] <= IW'(N - 1);
            end
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (!env && any_found) begin
                        tag_q.valid <= 1'b1;
                        tag_q.hi    <= use_hi;
                        idx_q       <= pick_idx;
                        timer_q     <= '0;
                        state_q     <= ARB_WAIT;
                        if (use_hi) last[LVL_HI] <= pick_idx;
                        else        last[LVL_LO] <= pick_idx;
                    end
                end
                ARB_WAIT: begin
                    if (env) begin
                        state_q <= ARB_BUSY;
                    end else if (timer_q == TW'(START_TIMEOUT - 1)) begin
                        tag_q   <= '0;
                        state_q <= ARB_IDLE;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ARB_BUSY: begin
                    if (!env) begin
                        tag_q   <= '0;
                        state_q <= ARB_IDLE;
                    end
                end
                default: begin
                    tag_q   <= '0;
                    state_q <= ARB_IDLE;
                end
            endcase
        end
    end

    assign gnt        = tag_q.valid ? (N'(1) << idx_q) : '0;
    assign data_cycle = (state_q != ARB_IDLE) && tag_q.valid && tag_q.hi && env;
endmodule

// File: rtl/msg_bus_arbiter.sv
`timescale 1ns/1ps
module msg_bus_arbiter
    import msgarb_pkg::*;
#(
    parameter int NUM_REQ       = 8,
    parameter int WINDOW        = 64,
    parameter int START_TIMEOUT = 4,
    localparam int IW = $clog2(NUM_REQ),
    localparam int CW = $clog2(WINDOW + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_n,
    input  logic               hp_req_n,
    input  logic [NUM_REQ-1:0] hp_flag,
    input  logic               msg_env_n,
    input  logic [CW-1:0]      ovld_thresh,
    output logic [NUM_REQ-1:0] gnt_n,
    output logic               ovld_n
);
    logic [NUM_LVL-1:0][NUM_REQ-1:0] lvl_elig;
    logic [NUM_LVL-1:0]              lvl_found;
    logic [NUM_LVL-1:0][IW-1:0]      lvl_win;
    logic [NUM_LVL-1:0][IW-1:0]      lvl_last;
    logic [NUM_REQ-1:0]              gnt;
    logic                            data_cycle;
    logic                            overload;

    assign lvl_elig[LVL_LO] = ~req_n;
    assign lvl_elig[LVL_HI] = ~req_n & hp_flag;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_level
        msgarb_rr_pick #(.N(NUM_REQ)) pick_i (
            .elig  (lvl_elig[l]),
            .last  (lvl_last[l]),
            .found (lvl_found[l]),
            .win   (lvl_win[l])
        );
    end

    msgarb_ctrl #(.N(NUM_REQ), .START_TIMEOUT(START_TIMEOUT)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .hp_line    (~hp_req_n),
        .env        (~msg_env_n),
        .found      (lvl_found),
        .win        (lvl_win),
        .gnt        (gnt),
        .last       (lvl_last),
        .data_cycle (data_cycle)
    );

    msgarb_load_reg #(.WINDOW(WINDOW)) load_i (
        .clk        (clk),
        .rst        (rst),
        .data_cycle (data_cycle),
        .thresh     (ovld_thresh),
        .overload   (overload)
    );

    assign gnt_n  = ~gnt;
    assign ovld_n = ~overload;
endmodule

// File: rtl/msgarb_chk.sv
`timescale 1ns/1ps
module msgarb_chk #(
    parameter int NUM_REQ       = 8,
    parameter int START_TIMEOUT = 4,
    localparam int HW = $clog2(START_TIMEOUT + 2)
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_n,
    input logic               hp_req_n,
    input logic [NUM_REQ-1:0] hp_flag,
    input logic               msg_env_n,
    input logic [NUM_REQ-1:0] gnt_n
);
    logic          env_seen_q;
    logic [HW-1:0] wait_q;
    logic          held;

    assign held = (gnt_n != '1);

    always_ff @(posedge clk) begin
        if (rst || !held) begin
            env_seen_q <= 1'b0;
            wait_q     <= '0;
        end else begin
            if (!msg_env_n) env_seen_q <= 1'b1;
            if (!env_seen_q && msg_env_n && wait_q != '1) wait_q <= wait_q + 1'b1;
        end
    end

    // R1
    reset_grant_chk: assert property (@(posedge clk) rst |=> (gnt_n == '1));

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(~gnt_n));

    // R3
    idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(gnt_n) == '1) && held) |->
        ($past(msg_env_n) && ((~gnt_n & ~$past(req_n)) != '0)));

    // R4
    hi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(gnt_n) == '1) && held && !$past(hp_req_n) &&
         ((~$past(req_n) & $past(hp_flag)) != '0)) |->
        ((~gnt_n & $past(hp_flag)) != '0));

    // R7
    env_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !msg_env_n) |=> $stable(gnt_n));

    // R8
    start_window_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !env_seen_q) |-> (wait_q < HW'(START_TIMEOUT)));
endmodule

bind msg_bus_arbiter msgarb_chk #(.NUM_REQ(NUM_REQ), .START_TIMEOUT(START_TIMEOUT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_n     (req_n),
    .hp_req_n  (hp_req_n),
    .hp_flag   (hp_flag),
    .msg_env_n (msg_env_n),
    .gnt_n     (gnt_n)
);

// File: tb/msg_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module msg_bus_arbiter_tb_top;
    localparam int N   = 8;
    localparam int WIN = 32;
    localparam int CW  = $clog2(WIN + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_n = '1;
    logic [N-1:0]  hp_flag = '0;
    logic          hp_force = 1'b0;
    logic          hp_req_n;
    logic          env_n = 1'b1;
    logic [CW-1:0] thresh = CW'(WIN);
    logic [N-1:0]  gnt_n;
    logic          ovld_n;

    int checks = 0;
    int failures = 0;
    int lo_last = N - 1;
    int hi_last = N - 1;
    bit finished = 1'b0;

    assign hp_req_n = ~(hp_force | (|(~req_n & hp_flag)));

    always #2.5 clk = ~clk;

    msg_bus_arbiter #(.NUM_REQ(N), .WINDOW(WIN), .START_TIMEOUT(4)) dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .hp_req_n(hp_req_n), .hp_flag(hp_flag),
        .msg_env_n(env_n), .ovld_thresh(thresh), .gnt_n(gnt_n), .ovld_n(ovld_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int rr_next(input logic [N-1:0] elig, input int last);
        for (int k = 1; k <= N; k++) begin
            if (elig[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] gmask(input int idx);
        return ~(N'(1) << idx);
    endfunction

    // Grant expected visible now; run a message of len cycles and check release.
    task automatic serve(input int idx, input int len, input bit hi, input string tag);
        chk(tag, 32'(gnt_n), 32'(gmask(idx)));
        req_n[idx] = 1'b1;
        env_n = 1'b0;
        if (hi) hi_last = idx; else lo_last = idx;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            chk("R7 hold", 32'(gnt_n), 32'(gmask(idx)));
        end
        env_n = 1'b1;
        @(negedge clk);
        chk("R7 release", 32'(gnt_n), 32'hFF);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 gnt in reset", 32'(gnt_n), 32'hFF);
        chk("R1 ovld in reset", 32'(ovld_n), 32'h1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 gnt after reset", 32'(gnt_n), 32'hFF);
    endtask

    task automatic t_single();
        req_n[3] = 1'b0;
        @(negedge clk);
        serve(3, 3, 1'b0, "R3 single grant");
        @(negedge clk);
        chk("R3 no request no grant", 32'(gnt_n), 32'hFF);
    endtask

    task automatic t_busy_bus();
        env_n = 1'b0;
        req_n[4] = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R3 busy bus blocks grant", 32'(gnt_n), 32'hFF);
        end
        env_n = 1'b1;
        @(negedge clk);
        serve(rr_next(~req_n, lo_last), 1, 1'b0, "R3 grant after idle");
        @(negedge clk);
    endtask

    task automatic t_rr_low();
        req_n = '0;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            serve(rr_next(~req_n, lo_last), 1, 1'b0, "R5 rotation");
            @(negedge clk);
        end
        chk("R2 all served", 32'(gnt_n), 32'hFF);
    endtask

    task automatic t_preempt();
        req_n = 8'hFC;
        @(negedge clk);
        chk("R5 first low", 32'(gnt_n), 32'(gmask(rr_next(8'h03, lo_last))));
        hp_flag[5] = 1'b1;
        hp_flag[6] = 1'b1;
        req_n[5] = 1'b0;
        req_n[6] = 1'b0;
        serve(rr_next(8'h03, lo_last), 2, 1'b0, "R6 low message");
        @(negedge clk);
        serve(rr_next(~req_n & hp_flag, hi_last), 1, 1'b1, "R4 preempt first");
        @(negedge clk);
        serve(rr_next(~req_n & hp_flag, hi_last), 1, 1'b1, "R4 preempt second");
        req_n[7] = 1'b0;
        @(negedge clk);
        chk("R6 low pointer kept", 32'(gnt_n), 32'(gmask(1)));
        serve(rr_next(~req_n, lo_last), 1, 1'b0, "R6 low resume");
        @(negedge clk);
        serve(rr_next(~req_n, lo_last), 1, 1'b0, "R6 low last");
        hp_flag = '0;
        @(negedge clk);
    endtask

    task automatic t_fallback();
        hp_force = 1'b1;
        req_n[3] = 1'b0;
        @(negedge clk);
        serve(rr_next(~req_n, lo_last), 1, 1'b0, "R4 fallback to low");
        hp_force = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_timeout();
        req_n[2] = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R8 grant before timeout", 32'(gnt_n), 32'(gmask(2)));
        end
        req_n[2] = 1'b1;
        lo_last = 2;
        @(negedge clk);
        chk("R8 withdrawn", 32'(gnt_n), 32'hFF);
        req_n[2] = 1'b0;
        req_n[3] = 1'b0;
        @(negedge clk);
        chk("R8 pointer advanced", 32'(gnt_n), 32'(gmask(3)));
        serve(3, 1, 1'b0, "R8 next winner");
        @(negedge clk);
        serve(2, 1, 1'b0, "R8 withdrawn served later");
        @(negedge clk);
    endtask

    task automatic t_overload();
        repeat (WIN + 2) @(negedge clk);
        thresh = CW'(5);
        #1;
        chk("R9 empty window", 32'(ovld_n), 32'h1);
        req_n[0] = 1'b0;
        @(negedge clk);
        serve(0, 8, 1'b0, "R9 low message");
        chk("R9 low not counted", 32'(ovld_n), 32'h1);
        @(negedge clk);
        hp_flag[4] = 1'b1;
        req_n[4] = 1'b0;
        @(negedge clk);
        chk("R9 hi grant", 32'(gnt_n), 32'(gmask(4)));
        req_n[4] = 1'b1;
        hi_last = 4;
        env_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R9 count edge", 32'(ovld_n), (k >= 5) ? 32'h0 : 32'h1);
        end
        env_n = 1'b1;
        @(negedge clk);
        chk("R7 hi release", 32'(gnt_n), 32'hFF);
        chk("R9 overload held", 32'(ovld_n), 32'h0);
        thresh = CW'(7);
        #1;
        chk("R9 raised budget", 32'(ovld_n), 32'h1);
        thresh = CW'(5);
        #1;
        chk("R9 budget restored", 32'(ovld_n), 32'h0);
        repeat (WIN - 8) @(negedge clk);
        chk("R9 still in window", 32'(ovld_n), 32'h0);
        repeat (10) @(negedge clk);
        chk("R9 window expired", 32'(ovld_n), 32'h1);
        hp_flag = '0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_busy_bus();
        t_rr_low();
        t_preempt();
        t_fallback();
        t_timeout();
        t_overload();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule